// File: doc/BRIEF.md
# Transfer Completion Status Queue

This block keeps a short queue of completion records for endpoint transfers. Each record gives the endpoint number, whether the transaction sent or received data, and which of the two ping-pong buffer banks it used. A producer adds one record with a one-cycle strobe each time a transaction finishes. The oldest record is shown through a 32-bit read-only status word.

A transaction-done flag tells software that a record is waiting. Software reads the status word and then writes one to clear the flag. That clear removes the head record. If more records are queued, the flag comes back one cycle later and the next record appears.

A record that arrives while the queue is full is discarded. A sticky overflow bit records the loss until software clears it.

Top module: `xfer_stat_fifo`

## Requirements
- R1: After reset, the status word is zero, the done flag is 0 and the overflow bit is 0.
- R2: A push sets the done flag at the next clock edge. While the flag is set, the status word shows the head record: endpoint in bits 7:4, direction in bit 3 (1 = transmit, 0 = receive), bank in bit 2 (1 = odd, 0 = even). Bits 31:8 and 1:0 are zero.
- R3: A push made while four records are held, with no pop in the same cycle, is discarded and sets the overflow bit. The overflow bit stays set until it is cleared.
- R4: Records are presented in the order they were pushed. The queue holds up to four records.
- R5: A flag clear made while the flag is 1 removes the head record and drives the flag to 0 for one cycle. In the next cycle the flag is 1 if records remain and 0 otherwise.
- R6: The status word reads all zeros whenever the done flag is 0.
- R7: A flag clear made while the flag is 0 does not change the queue contents.
- R8: A push and an accepted clear in the same cycle are both performed. The record count does not change, no overflow is raised, and this also holds when the queue is full.
- R9: An overflow-clear strobe resets the overflow bit. If a discarded push happens in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_done_i | input | 1 | Push strobe, one record per cycle |
| xfer_ep_i | input | 4 | Endpoint number of the finished transaction |
| xfer_tx_i | input | 1 | 1 = transmit, 0 = receive |
| xfer_odd_i | input | 1 | 1 = odd bank, 0 = even bank |
| flag_clr_i | input | 1 | Write-one-to-clear of the done flag; pops the head record |
| ovf_clr_i | input | 1 | Write-one-to-clear of the overflow bit |
| stat_o | output | 32 | Status word showing the head record |
| done_flag_o | output | 1 | Transaction-done flag |
| ovf_o | output | 1 | Sticky overflow bit |

## Verification
Single push-and-pop pairs check the field layout. They use endpoint numbers near both ends of the range and every combination of the direction and bank bits, so a swapped or shifted bit shows up. Four distinct records pushed back to back and then drained check the ordering and the full depth. A fifth push then tells a discarding queue apart from one that overwrites its head or tail. Clear strobes given during the one-cycle flag gap or on an empty queue separate a proper no-op from an extra pop. A push issued together with a clear on a full queue checks that the simultaneous path keeps both records and raises no false overflow.

// File: rtl/xfer_stat_pkg.sv
package xfer_stat_pkg;
  localparam int EP_W     = 4;
  localparam int STAT_W   = 32;
  // field positions decoded by software
  localparam int EP_LSB   = 4;
  localparam int DIR_BIT  = 3;
  localparam int BANK_BIT = 2;

  typedef struct packed {
    logic [EP_W-1:0] ep;
    logic            tx;
    logic            odd;
  } xfer_rec_t;
endpackage

// File: rtl/xfer_stat_queue.sv
module xfer_stat_queue
  import xfer_stat_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  xfer_rec_t        wr_rec_i,
  input  logic             rd_en_i,
  output xfer_rec_t        head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             nz_next_o,
  output logic             drop_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  xfer_rec_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty, wr_ok, rd_ok;

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign rd_ok = rd_en_i & ~empty;
  // a full queue still accepts when a pop frees a slot this cycle
  assign wr_ok = wr_en_i & (~full | rd_ok);
  assign drop_o = wr_en_i & ~wr_ok;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_ok && !rd_ok)      cnt_d = cnt_q + 1'b1;
    else if (!wr_ok && rd_ok) cnt_d = cnt_q - 1'b1;
  end

  assign nz_next_o = (cnt_d != '0);
  assign count_o   = cnt_q;
  assign head_o    = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[i] <= '0;
      else if (wr_ok && wr_ptr_q == PTR_W'(i))       mem_q[i] <= wr_rec_i;
    end
  end
endmodule

// File: rtl/xfer_stat_flags.sv
module xfer_stat_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_clr_i,
  input  logic ovf_clr_i,
  input  logic nz_next_i,
  input  logic drop_i,
  output logic pop_o,
  output logic flag_o,
  output logic ovf_o
);
  logic flag_q, ovf_q;

  // clear is honoured only while the flag is up
  assign pop_o = flag_clr_i & flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      flag_q <= pop_o ? 1'b0 : nz_next_i;
      if (drop_i)         ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/xfer_stat_view.sv
module xfer_stat_view
  import xfer_stat_pkg::*;
(
  input  logic              valid_i,
  input  xfer_rec_t         head_i,
  output logic [STAT_W-1:0] stat_o
);
  always_comb begin
    stat_o = '0;
    if (valid_i) begin
      stat_o[EP_LSB +: EP_W] = head_i.ep;
      stat_o[DIR_BIT]        = head_i.tx;
      stat_o[BANK_BIT]       = head_i.odd;
    end
  end
endmodule

// File: rtl/xfer_stat_fifo.sv
module xfer_stat_fifo
  import xfer_stat_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_done_i,
  input  logic [EP_W-1:0]   xfer_ep_i,
  input  logic              xfer_tx_i,
  input  logic              xfer_odd_i,
  input  logic              flag_clr_i,
  input  logic              ovf_clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              done_flag_o,
  output logic              ovf_o
);
  xfer_rec_t        wr_rec, head;
  logic [CNT_W-1:0] q_count;
  logic             nz_next, drop, pop;

  assign wr_rec = '{ep: xfer_ep_i, tx: xfer_tx_i, odd: xfer_odd_i};

  xfer_stat_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (xfer_done_i),
    .wr_rec_i  (wr_rec),
    .rd_en_i   (pop),
    .head_o    (head),
    .count_o   (q_count),
    .nz_next_o (nz_next),
    .drop_o    (drop)
  );

  xfer_stat_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag_clr_i (flag_clr_i),
    .ovf_clr_i  (ovf_clr_i),
    .nz_next_i  (nz_next),
    .drop_i     (drop),
    .pop_o      (pop),
    .flag_o     (done_flag_o),
    .ovf_o      (ovf_o)
  );

  xfer_stat_view u_view (
    .valid_i (done_flag_o),
    .head_i  (head),
    .stat_o  (stat_o)
  );
endmodule

// File: rtl/xfer_stat_fifo_chk.sv
module xfer_stat_fifo_chk #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xfer_done_i,
  input logic             flag_clr_i,
  input logic             ovf_clr_i,
  input logic [31:0]      stat_o,
  input logic             done_flag_o,
  input logic             ovf_o,
  input logic [CNT_W-1:0] q_count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  p_push_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !done_flag_o) |=> done_flag_o);

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[31:8] == '0) && (stat_o[1:0] == 2'b00));

  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_count == FULL_CNT && xfer_done_i && !(flag_clr_i && done_flag_o))
      |=> (ovf_o && q_count == FULL_CNT));

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  p_depth_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= FULL_CNT);

  p_flag_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && done_flag_o) |=> !done_flag_o);

  p_zero_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_flag_o |-> (stat_o == '0));

  p_noop_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !done_flag_o && !xfer_done_i) |=> (q_count == $past(q_count)));

  p_same_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && flag_clr_i && done_flag_o) |=> (q_count == $past(q_count) && !$rose(ovf_o)));
endmodule

bind xfer_stat_fifo xfer_stat_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_done_i (xfer_done_i),
  .flag_clr_i  (flag_clr_i),
  .ovf_clr_i   (ovf_clr_i),
  .stat_o      (stat_o),
  .done_flag_o (done_flag_o),
  .ovf_o       (ovf_o),
  .q_count     (q_count)
);

// File: tb/xfer_stat_fifo_bench.sv
`timescale 1ns/1ps
module xfer_stat_fifo_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_i = 1'b0, tx_i = 1'b0, odd_i = 1'b0, fclr = 1'b0, oclr = 1'b0;
  logic [3:0]  ep_i = '0;
  logic [31:0] stat;
  logic        flag, ovf;

  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;
  logic [7:0] exp_q[$];
  logic       exp_ovf = 1'b0;

  always #5 clk = ~clk;

  xfer_stat_fifo u_xfer_stat_fifo (
    .clk_i(clk), .rst_ni(rst_n), .xfer_done_i(done_i), .xfer_ep_i(ep_i),
    .xfer_tx_i(tx_i), .xfer_odd_i(odd_i), .flag_clr_i(fclr), .ovf_clr_i(oclr),
    .stat_o(stat), .done_flag_o(flag), .ovf_o(ovf));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rec(input logic [3:0] ep, input logic tx, input logic odd);
    return {ep, tx, odd, 2'b00};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // driver: pushes one record and updates the scoreboard
  task automatic push_rec(input logic [3:0] ep, input logic tx, input logic odd);
    done_i = 1'b1; ep_i = ep; tx_i = tx; odd_i = odd;
    if (exp_q.size() < DEPTH) exp_q.push_back(rec(ep, tx, odd));
    else exp_ovf = 1'b1;
    tick();
    done_i = 1'b0;
  endtask

  // monitor: compares the head against the scoreboard, then pops it
  task automatic pop_cmp(input string req);
    logic [7:0] e;
    e = exp_q.pop_front();
    check(flag === 1'b1, req, {31'b0, flag}, 32'd1);
    check(stat === {24'h0, e}, req, stat, {24'h0, e});
    fclr = 1'b1;
    tick();
    fclr = 1'b0;
    check(flag === 1'b0 && stat === 32'h0, "R5/R6 gap", {flag, stat[30:0]}, 32'h0);
    tick();
    check(flag === (exp_q.size() != 0), "R5 refill", {31'b0, flag}, {31'b0, exp_q.size() != 0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(stat === 32'h0 && flag === 1'b0 && ovf === 1'b0, "R1", {ovf, flag, stat[29:0]}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R2 field layout, several patterns
    push_rec(4'h5, 1'b1, 1'b0);
    check(flag === 1'b1, "R2 flag", {31'b0, flag}, 32'd1);
    pop_cmp("R2 ep5 tx even");
    push_rec(4'hF, 1'b0, 1'b1);
    pop_cmp("R2 ep15 rx odd");
    push_rec(4'h0, 1'b1, 1'b1);
    pop_cmp("R2 ep0 tx odd");
    push_rec(4'hA, 1'b0, 1'b0);
    pop_cmp("R2 ep10 rx even");

    // R7 clear on empty queue
    fclr = 1'b1; tick(); fclr = 1'b0;
    check(flag === 1'b0 && stat === 32'h0, "R7 empty clr", stat, 32'h0);
    tick();
    check(flag === 1'b0, "R7 empty clr flag", {31'b0, flag}, 32'h0);

    // R7 clear in the gap cycle must not pop
    push_rec(4'h3, 1'b0, 1'b1);
    push_rec(4'h9, 1'b1, 1'b0);
    void'(exp_q.pop_front());
    fclr = 1'b1; tick();        // accepted pop
    check(flag === 1'b0, "R5 gap", {31'b0, flag}, 32'h0);
    tick();                     // clear during gap, no effect
    fclr = 1'b0;
    check(flag === 1'b1 && stat === {24'h0, exp_q[0]}, "R7 gap clr", stat, {24'h0, exp_q[0]});
    pop_cmp("R7 survivor");

    // R4 ordering at full depth
    push_rec(4'h1, 1'b0, 1'b0);
    push_rec(4'h2, 1'b1, 1'b0);
    push_rec(4'h4, 1'b0, 1'b1);
    push_rec(4'h8, 1'b1, 1'b1);
    check(ovf === 1'b0, "R4 no ovf at depth", {31'b0, ovf}, 32'h0);
    for (int i = 0; i < DEPTH; i++) pop_cmp("R4 order");

    // R3 overflow, R9 set beats clear
    push_rec(4'hC, 1'b0, 1'b0);
    push_rec(4'hD, 1'b1, 1'b0);
    push_rec(4'hE, 1'b0, 1'b1);
    push_rec(4'h7, 1'b1, 1'b1);
    push_rec(4'h6, 1'b1, 1'b1);  // dropped
    check(ovf === exp_ovf, "R3 ovf set", {31'b0, ovf}, {31'b0, exp_ovf});
    tick();
    check(ovf === 1'b1, "R3 sticky", {31'b0, ovf}, 32'd1);
    oclr = 1'b1;
    push_rec(4'hB, 1'b0, 1'b0);  // dropped alongside clear
    oclr = 1'b0;
    check(ovf === 1'b1, "R9 set wins", {31'b0, ovf}, 32'd1);
    oclr = 1'b1; tick(); oclr = 1'b0; exp_ovf = 1'b0;
    check(ovf === 1'b0, "R9 clear", {31'b0, ovf}, 32'h0);
    for (int i = 0; i < DEPTH; i++) pop_cmp("R3 kept first four");
    check(flag === 1'b0, "R3 drained", {31'b0, flag}, 32'h0);

    // R8 simultaneous push and pop on a full queue
    push_rec(4'h1, 1'b1, 1'b0);
    push_rec(4'h2, 1'b0, 1'b1);
    push_rec(4'h3, 1'b1, 1'b1);
    push_rec(4'h4, 1'b0, 1'b0);
    check(stat === {24'h0, exp_q[0]}, "R8 head", stat, {24'h0, exp_q[0]});
    void'(exp_q.pop_front());
    fclr = 1'b1;
    push_rec(4'h5, 1'b1, 1'b1);
    fclr = 1'b0;
    check(ovf === 1'b0 && flag === 1'b0, "R8 no ovf", {30'b0, ovf, flag}, 32'h0);
    tick();
    check(exp_q.size() == DEPTH && flag === 1'b1, "R8 count kept", exp_q.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_cmp("R8 order");
    check(flag === 1'b0 && ovf === 1'b0, "R8 end", {30'b0, ovf, flag}, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule